// File: doc/BRIEF.md
# Serial Byte Transmitter with Two-Step Host Handshake

This block turns one byte from a host's parallel bus into an asynchronous serial frame on a single output line. The host works in two steps. First it raises a byte-ready strobe, and the block copies the bus into a holding register. Later it raises a transmit strobe, and the block moves the held byte into a shift register and starts the frame. A three-state controller (idle, waiting, sending) sequences these steps.

Line timing comes from an external single-cycle baud tick. While sending, the block advances the line by one bit on each tick, and the line rests high whenever no frame is in progress. A busy output tells the host when the block is not idle.

Top module: `uart_tx_hs`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_out` is 1 and `busy` is 0.
- R2: In idle, a high `byte_ready` at a clock edge captures `data_in` and moves the block to waiting (busy goes high, `tx_out` stays 1 even if `xmit_byte` is high at that same edge). A high `xmit_byte` alone in idle has no effect.
- R3: In waiting, a high `xmit_byte` at a clock edge loads the frame and enters sending, so `tx_out` is 0 (the start bit) right after that edge. `baud_tick` pulses in waiting leave `tx_out` at 1.
- R4: A frame on `tx_out` is, in time order: start bit 0, data bit 0 up to data bit 7 (least significant first), the parity bit, then stop bit 1.
- R5: The parity bit is the XOR of the eight data bits, which makes the count of ones over data plus parity even.
- R6: While sending, `tx_out` changes only after an edge where `baud_tick` is high. A tick at the same edge that loads the frame is not counted, so that start bit lasts exactly one tick interval from the load.
- R7: At the tick that ends the stop bit, the block returns to idle: on the next cycle `busy` is 0 and `tx_out` is 1. The bit counter restarts, so a following frame again has all eleven bits.
- R8: The holding register changes only in idle. A `byte_ready` pulse while waiting or sending neither alters the byte that is sent nor keeps the block out of idle after the frame.
- R9: `busy` is 1 in waiting and in sending, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse marking each bit period |
| data_in | input | 8 | Parallel byte from the host |
| byte_ready | input | 1 | Host strobe: bus holds a valid byte |
| xmit_byte | input | 1 | Host strobe: start sending the held byte |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | High whenever the controller is not idle |

## Verification
Two overlaps matter most here. The first is a baud tick landing on the same edge as the transmit strobe. The bench aligns the strobe with a tick and then counts how many cycles the line stays low, expecting exactly one tick period. The second is both host strobes raised together in idle. The bench checks that only the capture happens on that edge and that the frame starts one edge later. A scoreboard compares every bit sampled on a tick against the frame it predicted from the byte alone.

// File: rtl/uart_tx_hs_pkg.sv
package uart_tx_hs_pkg;

    // Default payload width and the frame it implies (start + data + parity + stop)
    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    // Datapath commands issued by the controller for one cycle
    typedef struct packed {
        logic hold_ld;   // capture host bus into holding register
        logic shift_ld;  // load frame into shift register
        logic shift_en;  // advance line by one bit
        logic cnt_inc;   // count one transmitted bit
        logic cnt_clr;   // restart bit counter
    } tx_cmd_t;

    localparam tx_cmd_t CMD_NONE = '{default: 1'b0};

    // Frame length for a payload width
    function automatic int frame_len(input int w);
        return w + 3;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
// Holding register for the byte handed over by the host
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/uart_tx_bitcnt.sv
// Counts bit periods of the frame in flight
module uart_tx_bitcnt #(
    parameter int FRAME_W = 11,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The last index is the stop bit's period
    assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/uart_tx_shifter.sv
// Frame shift register: loads start/data/parity/stop, shifts toward bit 0,
// refilling the top with the line's resting level.
module uart_tx_shifter #(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  uart_tx_hs_pkg::tx_cmd_t             cmd,
    input  logic [DATA_W-1:0]                   din,
    output logic [FRAME_W-1:0]                  sreg,
    output logic                                ser
);
    logic par_bit;
    logic [FRAME_W-1:0] frame_img;

    // Even parity: XOR of the payload
    assign par_bit   = ^din;
    assign frame_img = {1'b1, par_bit, din, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
        end else if (cmd.shift_ld) begin
            sreg <= frame_img;
        end else if (cmd.shift_en) begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
        end
    end

    assign ser = sreg[0];
endmodule

// File: rtl/uart_tx_ctrl.sv
// Three-state handshake and framing controller
module uart_tx_ctrl
    import uart_tx_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      byte_ready,
    input  logic      xmit_byte,
    input  logic      baud_tick,
    input  logic      cnt_last,
    output tx_cmd_t   cmd,
    output tx_state_e state
);
    tx_state_e nxt;

    always_comb begin
        nxt = state;
        cmd = CMD_NONE;
        unique case (state)
            ST_IDLE: begin
                if (byte_ready) begin
                    cmd.hold_ld = 1'b1;
                    nxt         = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (xmit_byte) begin
                    cmd.shift_ld = 1'b1;
                    cmd.cnt_clr  = 1'b1;
                    nxt          = ST_SEND;
                end
            end
            ST_SEND: begin
                if (baud_tick) begin
                    if (cnt_last) begin
                        cmd.cnt_clr = 1'b1;
                        nxt         = ST_IDLE;
                    end else begin
                        cmd.shift_en = 1'b1;
                        cmd.cnt_inc  = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/uart_tx_hs.sv
// Top: serial byte transmitter with two-step host handshake
module uart_tx_hs
    import uart_tx_hs_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int FRAME_W = DATA_W + 3,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] data_in,
    input  logic              byte_ready,
    input  logic              xmit_byte,
    output logic              tx_out,
    output logic              busy
);
    tx_cmd_t            cmd;
    tx_state_e          st;
    logic [DATA_W-1:0]  hold_q;
    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_last;

    uart_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .byte_ready (byte_ready),
        .xmit_byte  (xmit_byte),
        .baud_tick  (baud_tick),
        .cnt_last   (cnt_last),
        .cmd        (cmd),
        .state      (st)
    );

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (cmd.hold_ld),
        .din  (data_in),
        .q    (hold_q)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .din  (hold_q),
        .sreg (sreg),
        .ser  (tx_out)
    );

    uart_tx_bitcnt #(.FRAME_W(FRAME_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd.cnt_clr),
        .inc  (cmd.cnt_inc),
        .cnt  (cnt),
        .last (cnt_last)
    );

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/uart_tx_hs_chk.sv
// Property checker bound into the transmitter top
module uart_tx_hs_chk
    import uart_tx_hs_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + 3,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input logic               clk,
    input logic               rst,
    input logic               baud_tick,
    input logic               tx_out,
    input logic               busy,
    input tx_state_e          state,
    input logic [DATA_W-1:0]  hold,
    input logic [FRAME_W-1:0] sreg,
    input logic [CNT_W-1:0]   cnt
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (tx_out && !busy)); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_WAIT && state == ST_SEND) |-> !tx_out); // R3

    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_WAIT && state == ST_SEND) |-> (sreg[FRAME_W-2] == ^hold)); // R5

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SEND && state == ST_SEND && !$past(baud_tick)) |-> $stable(tx_out)); // R6

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (tx_out && !busy)); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W - 1)); // R7

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(hold)); // R8

    AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (busy && tx_out)); // R9
endmodule

bind uart_tx_hs uart_tx_hs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .tx_out    (tx_out),
    .busy      (busy),
    .state     (st),
    .hold      (hold_q),
    .sreg      (sreg),
    .cnt       (cnt)
);

// File: tb/sim_uart_tx_hs.sv
`timescale 1ns/1ps
module sim_uart_tx_hs;
    localparam int DW = 8;
    localparam int FW = DW + 3;
    localparam int TP = 5;          // clock cycles per baud tick

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          byte_ready = 1'b0;
    logic          xmit_byte = 1'b0;
    logic          tx_out, busy, baud_tick;

    int tcnt = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic exp_q[$];
    bit   mon_active = 1'b0;
    bit   end_pend = 1'b0;
    int   nbits = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Tick generator: changes on falling edges, seen stable at rising edges
    always @(negedge clk) tcnt <= (tcnt == TP - 1) ? 0 : tcnt + 1;
    assign baud_tick = (tcnt == 0);

    uart_tx_hs u0 (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .data_in    (data_in),
        .byte_ready (byte_ready),
        .xmit_byte  (xmit_byte),
        .tx_out     (tx_out),
        .busy       (busy)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    // Monitor: samples the line before each tick while a frame is in flight
    always @(negedge clk) begin
        #2;
        if (end_pend) begin
            chk("R7", busy, 0, "busy after stop bit");
            chk("R7", tx_out, 1, "line after stop bit");
            end_pend = 1'b0;
        end
        if (mon_active && baud_tick) begin
            if (exp_q.size() == 0) begin
                chk("R4", 0, 1, "scoreboard empty");
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk((nbits == FW - 2) ? "R5" : "R4", tx_out, e, $sformatf("frame bit %0d", nbits));
            end
            nbits++;
            if (nbits == FW) begin
                nbits = 0;
                mon_active = 1'b0;
                end_pend = 1'b1;
            end
        end
    end

    task automatic load_byte(input logic [DW-1:0] d);
        data_in = d;
        byte_ready = 1'b1;
        step();
        byte_ready = 1'b0;
        chk("R9", busy, 1, "busy in waiting");
        chk("R2", tx_out, 1, "line while waiting");
    endtask

    // Push expected frame, strobe transmit, optionally aligned with a tick
    task automatic start_frame(input logic [DW-1:0] d, input bit align, input bit measure);
        int lowc;
        exp_q.push_back(1'b0);
        for (int i = 0; i < DW; i++) exp_q.push_back(d[i]);
        exp_q.push_back(^d);
        exp_q.push_back(1'b1);
        if (align) begin
            while (!baud_tick) step();
        end
        xmit_byte = 1'b1;
        step();
        xmit_byte = 1'b0;
        chk("R3", tx_out, 0, "start bit after transmit strobe");
        chk("R9", busy, 1, "busy in sending");
        mon_active = 1'b1;
        if (measure) begin
            lowc = 0;
            while (tx_out == 1'b0 && lowc < 4 * TP) begin
                lowc++;
                step();
            end
            chk("R6", lowc, TP, "start bit length with tick on load edge");
        end
    endtask

    task automatic wait_frame;
        step();
        while (mon_active || end_pend) step();
    endtask

    task automatic send(input logic [DW-1:0] d, input bit align, input bit measure);
        load_byte(d);
        start_frame(d, align, measure);
        wait_frame();
    endtask

    initial begin
        repeat (4) step();
        chk("R1", tx_out, 1, "line in reset");
        chk("R1", busy, 0, "busy in reset");
        rst = 1'b0;
        step();
        chk("R1", tx_out, 1, "line after reset");
        chk("R1", busy, 0, "busy after reset");

        // R2: transmit strobe alone in idle is ignored
        xmit_byte = 1'b1;
        repeat (3) step();
        xmit_byte = 1'b0;
        chk("R2", busy, 0, "busy after lone transmit strobe");
        chk("R2", tx_out, 1, "line after lone transmit strobe");

        // R4/R5/R7: several data patterns, back to back
        send(8'hA5, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        send(8'hFF, 1'b0, 1'b0);
        send(8'h80, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b0);

        // R6: transmit strobe on the same edge as a tick
        send(8'h01, 1'b1, 1'b1);
        send(8'h6E, 1'b1, 1'b0);

        // R3/R8: ticks and a new byte_ready while waiting are ignored
        load_byte(8'h5A);
        repeat (3 * TP) step();
        chk("R3", tx_out, 1, "line after ticks in waiting");
        data_in = 8'hFF;
        byte_ready = 1'b1;
        step();
        byte_ready = 1'b0;
        chk("R8", busy, 1, "still waiting after second byte_ready");
        start_frame(8'h5A, 1'b0, 1'b0);
        wait_frame();

        // R2: both strobes together in idle only capture
        data_in = 8'h3C;
        byte_ready = 1'b1;
        xmit_byte = 1'b1;
        step();
        byte_ready = 1'b0;
        chk("R2", busy, 1, "capture with both strobes");
        chk("R2", tx_out, 1, "no start on capture edge");
        start_frame(8'h3C, 1'b0, 1'b0);
        wait_frame();

        // R8: byte_ready during sending does not hold the block out of idle
        load_byte(8'hC3);
        start_frame(8'hC3, 1'b0, 1'b0);
        repeat (20) step();
        data_in = 8'h11;
        byte_ready = 1'b1;
        step();
        byte_ready = 1'b0;
        wait_frame();
        repeat (3) step();
        chk("R8", busy, 0, "idle after byte_ready during sending");
        chk("R8", exp_q.size(), 0, "scoreboard drained");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule